// File: doc/BRIEF.md
# MCMC Order Walker

The block steps a Markov-chain random walk over orderings of the nodes of a small network. It keeps the accepted ordering, a permutation of `N_NODES` node indices, with its log-domain score. Each iteration draws two distinct positions from an internal LFSR and exchanges the nodes held there. It then places the resulting proposal on a broadcast port for the external scoring units and waits for a score strobe. When the strobe arrives, it keeps or discards the proposal with a Metropolis-Hastings test carried out on log scores.

A controller starts a run by pulsing `start` with the number of iterations in `run_iters`. That count is the external stop condition. Between runs the walk keeps its state, so a later run continues from the last accepted ordering. Every iteration ends with a one-cycle `done` pulse that carries the decision and a running iteration count. A reference model seeded with the same LFSR value can follow the walk step by step.

Top module: `mcmc_order_walker`

## Requirements
- R1: After reset the accepted ordering is the identity (slot i holds node i, slot i occupying bits [4i+3:4i]). The accepted score is the most negative 24-bit value, the iteration count is 0, and `prop_valid`, `done` and `busy` are low.
- R2: The random source is a 16-bit Galois LFSR that resets to 0xACE1 and steps as next = (v >> 1) XOR (v[0] ? 0xB400 : 0). It steps once in every draw cycle and once in every decision cycle. A draw takes position A from v[3:0] and position B from v[7:4]. When A equals B, the block draws again in the next cycle.
- R3: The proposal is the accepted ordering with the nodes in slots A and B exchanged. `prop_valid` stays high, and `prop_order` stays unchanged, until the cycle in which `score_valid` is seen.
- R4: `score_valid` has no effect while `prop_valid` is low.
- R5: Scores are signed 24-bit fixed point with 8 fractional bits. A proposal scoring at least the accepted score is always accepted.
- R6: In any other case, u = v[15:12] of the LFSR value in the decision cycle selects a threshold T(u) = round(256 * -ln((u + 0.5) / 16)). The proposal is accepted exactly when T(u) >= accepted score - proposed score.
- R7: On acceptance, the accepted ordering and score become the proposal and its score at the edge that takes the strobe. On rejection, both stay unchanged.
- R8: In the cycle after the strobe, `done` is high for exactly one cycle, `accepted` gives the decision, and `iter_count` has gone up by one.
- R9: A `start` pulse with count K > 0 runs exactly K iterations and then returns to idle (`busy` low, no further proposals). K = 0 starts nothing. The walk state carries over into the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, sampled while idle |
| run_iters | input | 16 | Number of iterations for the run |
| prop_order | output | 64 | Proposed ordering broadcast to the scorers |
| prop_valid | output | 1 | Proposal is valid and awaiting its score |
| score_in | input | 24 | Signed log score of the proposal |
| score_valid | input | 1 | Score strobe |
| cur_order | output | 64 | Accepted ordering |
| cur_score | output | 24 | Signed log score of the accepted ordering |
| done | output | 1 | One-cycle end-of-iteration pulse |
| accepted | output | 1 | Decision of the last iteration |
| iter_count | output | 16 | Iterations completed since reset |
| busy | output | 1 | A run is in progress |

## Verification
The proposal is due one cycle after the last draw cycle. A redraw on equal positions can stretch that gap, so the bench waits on `prop_valid` and compares the proposal against its own LFSR model. After that, it checks that the proposal is still held one cycle later. The decision, the updated ordering and score, and the count are all due exactly one cycle after the edge that takes `score_valid`. The bench checks them at the falling edge that follows the strobe cycle: the monitor pops the entry that the driver pushed just before it raised the strobe, and the driver confirms that `done` is high at that edge. The bench picks each score from the threshold it expects, so the case of a drop equal to the threshold and the case of a drop one above it both occur.

// File: rtl/mcmc_walk_pkg.sv
package mcmc_walk_pkg;

    localparam int THR_W = 10;
    localparam int U_W   = 4;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_DRAW,
        WALK_WAIT
    } walk_state_e;

    // Threshold for index u: round(256 * -ln((u + 0.5) / 16)), 8 fraction bits.
    function automatic logic [THR_W-1:0] neglog_threshold(input logic [U_W-1:0] u);
        logic [THR_W-1:0] t;
        case (u)
            4'd0:  t = 10'd887;
            4'd1:  t = 10'd606;
            4'd2:  t = 10'd475;
            4'd3:  t = 10'd389;
            4'd4:  t = 10'd325;
            4'd5:  t = 10'd273;
            4'd6:  t = 10'd231;
            4'd7:  t = 10'd194;
            4'd8:  t = 10'd162;
            4'd9:  t = 10'd133;
            4'd10: t = 10'd108;
            4'd11: t = 10'd85;
            4'd12: t = 10'd63;
            4'd13: t = 10'd43;
            4'd14: t = 10'd25;
            default: t = 10'd8;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mcmc_walk_lfsr.sv
module mcmc_walk_lfsr #(
    parameter int          W     = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          IDX_W = 4,
    parameter int          U_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] draw_a,
    output logic [IDX_W-1:0] draw_b,
    output logic [U_W-1:0]   draw_u
);

    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step) begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS[W-1:0] : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED[W-1:0];
        else        lfsr_q <= lfsr_d;
    end

    assign draw_a = lfsr_q[IDX_W-1:0];
    assign draw_b = lfsr_q[2*IDX_W-1:IDX_W];
    assign draw_u = lfsr_q[W-1 -: U_W];

    // A Galois register seeded non-zero never reaches the all-zero lock state.
    assert_lfsr_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/mcmc_pair_swap.sv
module mcmc_pair_swap #(
    parameter int N_NODES = 16,
    parameter int IDX_W   = $clog2(N_NODES)
) (
    input  logic [N_NODES*IDX_W-1:0] order_in,
    input  logic [IDX_W-1:0]         pos_a,
    input  logic [IDX_W-1:0]         pos_b,
    output logic [N_NODES*IDX_W-1:0] order_out
);

    logic [IDX_W-1:0] node_at_a, node_at_b;

    assign node_at_a = order_in[pos_a*IDX_W +: IDX_W];
    assign node_at_b = order_in[pos_b*IDX_W +: IDX_W];

    for (genvar s = 0; s < N_NODES; s++) begin : g_slot
        logic hit_a, hit_b;
        assign hit_a = (pos_a == IDX_W'(s));
        assign hit_b = (pos_b == IDX_W'(s));
        assign order_out[s*IDX_W +: IDX_W] = hit_a ? node_at_b :
                                             hit_b ? node_at_a :
                                             order_in[s*IDX_W +: IDX_W];
    end

endmodule

// File: rtl/mcmc_mh_accept.sv
module mcmc_mh_accept
    import mcmc_walk_pkg::*;
#(
    parameter int SCORE_W = 24
) (
    input  logic signed [SCORE_W-1:0] cur_score,
    input  logic signed [SCORE_W-1:0] prop_score,
    input  logic        [U_W-1:0]     u_idx,
    output logic                      accept
);

    logic signed [SCORE_W:0] drop;
    logic signed [SCORE_W:0] thr_ext;
    logic                    uphill;

    // One extra bit keeps the score difference from wrapping.
    assign drop    = {cur_score[SCORE_W-1], cur_score} - {prop_score[SCORE_W-1], prop_score};
    assign thr_ext = $signed({{(SCORE_W+1-THR_W){1'b0}}, neglog_threshold(u_idx)});
    assign uphill  = (prop_score >= cur_score);
    assign accept  = uphill || (drop <= thr_ext);

endmodule

// File: rtl/mcmc_order_walker.sv
module mcmc_order_walker
    import mcmc_walk_pkg::*;
#(
    parameter int          N_NODES   = 16,
    parameter int          SCORE_W   = 24,
    parameter int          ITER_W    = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [ITER_W-1:0]                     run_iters,
    output logic [N_NODES*$clog2(N_NODES)-1:0]    prop_order,
    output logic                                  prop_valid,
    input  logic signed [SCORE_W-1:0]             score_in,
    input  logic                                  score_valid,
    output logic [N_NODES*$clog2(N_NODES)-1:0]    cur_order,
    output logic signed [SCORE_W-1:0]             cur_score,
    output logic                                  done,
    output logic                                  accepted,
    output logic [ITER_W-1:0]                     iter_count,
    output logic                                  busy
);

    localparam int IDX_W   = $clog2(N_NODES);
    localparam int ORDER_W = N_NODES * IDX_W;
    localparam logic [SCORE_W-1:0] SCORE_FLOOR = {1'b1, {(SCORE_W-1){1'b0}}};

    typedef struct packed {
        walk_state_e         st;
        logic [ORDER_W-1:0]  cur_order;
        logic [SCORE_W-1:0]  cur_score;
        logic [ORDER_W-1:0]  prop_order;
        logic [ITER_W-1:0]   remaining;
        logic [ITER_W-1:0]   iter_count;
        logic                done;
        logic                accepted;
    } walk_t;

    function automatic logic [ORDER_W-1:0] identity_order();
        logic [ORDER_W-1:0] r;
        for (int i = 0; i < N_NODES; i++) r[i*IDX_W +: IDX_W] = IDX_W'(i);
        return r;
    endfunction

    walk_t walk_d, walk_q;

    logic             lfsr_step;
    logic [IDX_W-1:0] pos_a, pos_b;
    logic [U_W-1:0]   u_idx;
    logic [ORDER_W-1:0] swapped;
    logic             take_prop;

    mcmc_walk_lfsr #(
        .W(16), .TAPS(16'hB400), .SEED(LFSR_SEED), .IDX_W(IDX_W), .U_W(U_W)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(lfsr_step),
        .draw_a(pos_a), .draw_b(pos_b), .draw_u(u_idx)
    );

    mcmc_pair_swap #(.N_NODES(N_NODES), .IDX_W(IDX_W)) u_swap (
        .order_in(walk_q.cur_order), .pos_a(pos_a), .pos_b(pos_b), .order_out(swapped)
    );

    mcmc_mh_accept #(.SCORE_W(SCORE_W)) u_mh (
        .cur_score($signed(walk_q.cur_score)), .prop_score(score_in),
        .u_idx(u_idx), .accept(take_prop)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        lfsr_step   = 1'b0;
        case (walk_q.st)
            WALK_IDLE: begin
                if (start && (run_iters != '0)) begin
                    walk_d.remaining = run_iters;
                    walk_d.st        = WALK_DRAW;
                end
            end
            WALK_DRAW: begin
                lfsr_step = 1'b1;
                if (pos_a != pos_b) begin
                    walk_d.prop_order = swapped;
                    walk_d.st         = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (score_valid) begin
                    lfsr_step          = 1'b1;
                    walk_d.done        = 1'b1;
                    walk_d.accepted    = take_prop;
                    walk_d.iter_count  = walk_q.iter_count + 1'b1;
                    walk_d.remaining   = walk_q.remaining - 1'b1;
                    if (take_prop) begin
                        walk_d.cur_order = walk_q.prop_order;
                        walk_d.cur_score = score_in;
                    end
                    walk_d.st = (walk_q.remaining == ITER_W'(1)) ? WALK_IDLE : WALK_DRAW;
                end
            end
            default: walk_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q            <= '0;
            walk_q.st         <= WALK_IDLE;
            walk_q.cur_order  <= identity_order();
            walk_q.cur_score  <= SCORE_FLOOR;
            walk_q.prop_order <= identity_order();
        end else begin
            walk_q <= walk_d;
        end
    end

    assign prop_order = walk_q.prop_order;
    assign prop_valid = (walk_q.st == WALK_WAIT);
    assign cur_order  = walk_q.cur_order;
    assign cur_score  = $signed(walk_q.cur_score);
    assign done       = walk_q.done;
    assign accepted   = walk_q.accepted;
    assign iter_count = walk_q.iter_count;
    assign busy       = (walk_q.st != WALK_IDLE);

    // Checker logic: which node indices appear in the broadcast ordering.
    logic [N_NODES-1:0] seen_nodes;
    always_comb begin
        seen_nodes = '0;
        for (int i = 0; i < N_NODES; i++) seen_nodes[prop_order[i*IDX_W +: IDX_W]] = 1'b1;
    end

    assert_prop_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prop_valid) |-> (&seen_nodes));

    assert_prop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !score_valid) |=> (prop_valid && $stable(prop_order)));

    assert_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!prop_valid && score_valid) |=> !done);

    assert_uphill_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (accepted || ($signed($past(score_in)) < $signed($past(cur_score)))));

    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accepted) |-> ($stable(cur_order) && $stable(cur_score)));

    assert_accept_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accepted) |-> ((cur_order == $past(prop_order)) && (cur_score == $past(score_in))));

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && score_valid) |=> done);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_mcmc_order_walker.sv
`timescale 1ns/1ps
module sim_mcmc_order_walker;

    localparam int N   = 16;
    localparam int OW  = 64;
    localparam int SW  = 24;
    localparam int ITW = 16;
    localparam int MINV = -(1 << 23);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ITW-1:0] run_iters = '0;
    logic score_valid = 1'b0;
    logic signed [SW-1:0] score_in = '0;
    logic [OW-1:0] prop_order, cur_order;
    logic prop_valid, done, accepted, busy;
    logic signed [SW-1:0] cur_score;
    logic [ITW-1:0] iter_count;

    always #2.5 clk = ~clk;

    mcmc_order_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .run_iters(run_iters),
        .prop_order(prop_order), .prop_valid(prop_valid),
        .score_in(score_in), .score_valid(score_valid),
        .cur_order(cur_order), .cur_score(cur_score), .done(done),
        .accepted(accepted), .iter_count(iter_count), .busy(busy)
    );

    typedef struct {
        bit            acc;
        logic [OW-1:0] ord;
        int            score;
        int            iter;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_lfsr = 16'hACE1;
    int m_ord[N];
    int m_score = MINV;
    int m_iter  = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lstep(input logic [15:0] v);
        return (v >> 1) ^ (v[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic int thr_of(input int k);
        real x;
        x = -$ln((k + 0.5) / 16.0) * 256.0;
        return $rtoi(x + 0.5);
    endfunction

    function automatic logic [OW-1:0] pack_ord(input int o[N]);
        logic [OW-1:0] r;
        for (int i = 0; i < N; i++) r[i*4 +: 4] = 4'(o[i]);
        return r;
    endfunction

    // Monitor: pops one expected result for every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R8 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.tag, " R7 decision"}, 64'(accepted), 64'(e.acc));
                chk({e.tag, " R7 order"}, cur_order, e.ord);
                chk({e.tag, " R7 score"}, 64'(longint'(cur_score)), 64'(longint'(e.score)));
                chk({e.tag, " R8 count"}, 64'(iter_count), 64'(e.iter));
            end
        end
    end

    task automatic start_run(input int k);
        @(negedge clk);
        start = 1'b1;
        run_iters = ITW'(k);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Driver: model one iteration, push the expected result, answer with a score.
    // mode 0 uphill, 1 equal, 2 drop equals threshold, 3 drop one above, 4 large drop.
    task automatic run_iter(input int mode);
        int a, b, tmp, u, thr, ps, guard;
        int prop[N];
        bit acc;
        exp_t e;
        string tag;
        do begin
            a = int'(m_lfsr[3:0]);
            b = int'(m_lfsr[7:4]);
            m_lfsr = lstep(m_lfsr);
        end while (a == b);
        prop = m_ord;
        tmp = prop[a]; prop[a] = prop[b]; prop[b] = tmp;

        guard = 0;
        while (!prop_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R2/R3 proposal", prop_order, pack_ord(prop));
        @(negedge clk);
        chk("R3 proposal held", {63'd0, prop_valid}, 64'd1);
        chk("R3 proposal stable", prop_order, pack_ord(prop));

        u = int'(m_lfsr[15:12]);
        thr = thr_of(u);
        case (mode)
            0: begin ps = (m_score == MINV) ? 1000 : m_score + 37; tag = "R5 uphill"; end
            1: begin ps = m_score;           tag = "R5 equal"; end
            2: begin ps = m_score - thr;     tag = "R6 drop==threshold"; end
            3: begin ps = m_score - thr - 1; tag = "R6 drop>threshold"; end
            default: begin ps = m_score - 5000; tag = "R6 large drop"; end
        endcase
        acc = (ps >= m_score) || ((m_score - ps) <= thr);
        m_lfsr = lstep(m_lfsr);
        m_iter++;
        if (acc) begin
            m_ord = prop;
            m_score = ps;
        end
        e.acc = acc; e.ord = pack_ord(m_ord); e.score = m_score; e.iter = m_iter; e.tag = tag;
        sbq.push_back(e);

        score_in = SW'(ps);
        score_valid = 1'b1;
        @(negedge clk);
        score_valid = 1'b0;
        chk("R8 done due one cycle after strobe", {63'd0, done}, 64'd1);
    endtask

    task automatic finish_run();
        @(negedge clk);
        chk("R9 idle after run", {63'd0, busy}, 64'd0);
        repeat (4) @(negedge clk);
        chk("R9 no proposal after run", {63'd0, prop_valid}, 64'd0);
        chk("R9 count after run", 64'(iter_count), 64'(m_iter));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_ord[i] = i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 order", cur_order, pack_ord(m_ord));
        chk("R1 score", 64'(longint'(cur_score)), 64'(longint'(MINV)));
        chk("R1 count", 64'(iter_count), 64'd0);
        chk("R1 flags", {60'd0, prop_valid, done, busy, 1'b0}, 64'd0);

        // R4 strobe while idle
        score_in = 24'sd500000;
        score_valid = 1'b1;
        @(negedge clk);
        score_valid = 1'b0;
        chk("R4 no done", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R4 score untouched", 64'(longint'(cur_score)), 64'(longint'(MINV)));
        chk("R4 order untouched", cur_order, pack_ord(m_ord));

        // R9 zero count
        start_run(0);
        repeat (3) @(negedge clk);
        chk("R9 zero count stays idle", {62'd0, busy, prop_valid}, 64'd0);

        // First run
        start_run(6);
        run_iter(0);
        run_iter(0);
        run_iter(1);
        run_iter(2);
        run_iter(3);
        run_iter(4);
        finish_run();

        // Second run continues the walk
        start_run(5);
        run_iter(3);
        run_iter(2);
        run_iter(0);
        run_iter(4);
        run_iter(1);
        finish_run();

        chk("R8 scoreboard drained", 64'(sbq.size()), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule